// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for single-register loads and stores of words or bytes, together with the updated base-register value that some addressing forms write back. Each valid request supplies a base value, a second register value, a signed immediate, a shift kind and amount, an addressing-mode code and a byte/word select. One clock later the unit presents the effective address, the writeback value, a writeback enable, the byte lane and a word-misalignment flag, qualified by an output valid.

The offset added to the base comes either from the sign-extended immediate or from the second register. The register can be used as it is, or shifted left, shifted right logically, or shifted right arithmetically by a constant amount. The addressing mode decides two things: whether the memory access uses the sum or the unmodified base, and whether the sum is returned for writeback. Plain register-indirect access is the offset mode with a zero immediate.

Top module: `lsagu_top`

## Requirements
- R1: Mode code 00 (offset): eff_addr = base + offset, wb_value = base + offset, wb_en = 0.
- R2: Mode code 01 (pre-indexed): eff_addr = base + offset, wb_value = eff_addr, wb_en = 1.
- R3: Mode code 10 (post-indexed): eff_addr = base (unmodified), wb_value = base + offset, wb_en = 1.
- R4: Mode code 11 (reserved) produces the offset-mode addresses and wb_en = 0.
- R5: All sums are taken modulo 2^32; when off_src = 0 the 12-bit imm_off is sign-extended to 32 bits and used as the offset.
- R6: When off_src = 1 the offset is reg_off shifted by shift_amt according to shift_kind: 00 logical left, 01 logical right, 10 arithmetic right (sign bit replicated), 11 no shift.
- R7: A shift_amt of 0 or of 32 and above leaves reg_off unshifted; amounts 1 to 31 are applied exactly.
- R8: off_src selects the offset source (0 immediate, 1 register); the source not selected has no effect on any output.
- R9: For a word access (is_byte = 0) misalign = 1 exactly when eff_addr[1:0] != 0 and byte_lane = 0; for a byte access misalign = 0 and byte_lane = eff_addr[1:0].
- R10: out_valid is in_valid delayed by one clock; the other outputs describe the request accepted on that edge, and wb_en is never 1 while out_valid is 0.
- R11: While rst_n is low, out_valid and wb_en are 0, taking effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| addr_mode | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 reserved |
| off_src | input | 1 | 0 immediate offset, 1 register offset |
| base_val | input | 32 | Base register value |
| reg_off | input | 32 | Register offset value |
| imm_off | input | 12 | Signed immediate offset |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 none |
| shift_amt | input | 6 | Shift amount for the register offset |
| is_byte | input | 1 | 1 byte access, 0 word access |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective address |
| wb_value | output | 32 | Base writeback value |
| wb_en | output | 1 | Base writeback enable |
| byte_lane | output | 2 | Byte lane of a byte access |
| misalign | output | 1 | Word access not on a 4-byte boundary |

## Verification
A fault in the shifter or the offset select shows as a wrong eff_addr or wb_value on the very next output cycle, but only for requests whose mode sends the sum to that port, so every mode is exercised with every offset form. A wrong mode decode shows at once on wb_en, or as eff_addr equal to the sum where the base is expected. The bench recomputes each result from the inputs it drove the cycle before and compares every port on every clock, so a fault is reported in the cycle after the request that exposes it.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'b00,
    AM_PRE    = 2'b01,
    AM_POST   = 2'b10,
    AM_RSVD   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SK_LSL  = 2'b00,
    SK_LSR  = 2'b01,
    SK_ASR  = 2'b10,
    SK_NONE = 2'b11
  } shift_kind_e;

endpackage

// File: rtl/lsagu_offset_sel.sv
module lsagu_offset_sel
  import lsagu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 6
) (
  input  logic               use_reg_i,
  input  logic [DW-1:0]      reg_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [1:0]         kind_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [DW-1:0]      offset_o
);

  localparam int LOG_DW = $clog2(DW);

  shift_kind_e       kind;
  logic              amt_ok;
  logic [LOG_DW-1:0] amt_eff;
  logic              is_lsl;
  logic              fill;
  logic [DW-1:0]     rev_in;
  logic [DW-1:0]     rev_out;
  logic [DW-1:0]     shifted;
  logic [DW-1:0]     imm_ext;
  logic [DW-1:0]     stg [LOG_DW+1];

  assign kind    = shift_kind_e'(kind_i);
  // Amounts of zero or at/above the data width are treated as no shift.
  assign amt_ok  = ((amt_i >> LOG_DW) == '0) && (amt_i[LOG_DW-1:0] != '0) && (kind != SK_NONE);
  assign amt_eff = amt_ok ? amt_i[LOG_DW-1:0] : '0;
  assign is_lsl  = (kind == SK_LSL);
  assign fill    = (kind == SK_ASR) & reg_i[DW-1];

  // Left shifts reuse the right shifter on the bit-reversed operand.
  generate
    for (genvar i = 0; i < DW; i++) begin : g_rev
      assign rev_in[i]  = reg_i[DW-1-i];
      assign rev_out[i] = stg[LOG_DW][DW-1-i];
    end
  endgenerate

  assign stg[0] = is_lsl ? rev_in : reg_i;

  generate
    for (genvar k = 0; k < LOG_DW; k++) begin : g_stage
      localparam int SH = 1 << k;
      assign stg[k+1] = amt_eff[k] ? {{SH{fill}}, stg[k][DW-1:SH]} : stg[k];
    end
  endgenerate

  assign shifted  = is_lsl ? rev_out : stg[LOG_DW];
  assign imm_ext  = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign offset_o = use_reg_i ? shifted : imm_ext;

endmodule

// File: rtl/lsagu_addr_calc.sv
module lsagu_addr_calc
  import lsagu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] offset_i,
  output logic [DW-1:0] ea_o,
  output logic [DW-1:0] wbv_o,
  output logic          wb_o
);

  addr_mode_e    mode;
  logic [DW-1:0] sum;

  assign mode = addr_mode_e'(mode_i);
  assign sum  = base_i + offset_i;

  always_comb begin
    ea_o  = sum;
    wbv_o = sum;
    wb_o  = 1'b0;
    unique case (mode)
      AM_PRE:  wb_o = 1'b1;
      AM_POST: begin
        ea_o = base_i;
        wb_o = 1'b1;
      end
      default: wb_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsagu_lane_chk.sv
module lsagu_lane_chk #(
  parameter int ALIGN_BITS = 2
) (
  input  logic [ALIGN_BITS-1:0] ea_lo_i,
  input  logic                  is_byte_i,
  output logic [ALIGN_BITS-1:0] lane_o,
  output logic                  misalign_o
);

  assign lane_o     = is_byte_i ? ea_lo_i : '0;
  assign misalign_o = ~is_byte_i & (ea_lo_i != '0);

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int IMM_W      = 12,
  parameter int SHAMT_W    = 6,
  parameter int ALIGN_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            addr_mode,
  input  logic                  off_src,
  input  logic [DW-1:0]         base_val,
  input  logic [DW-1:0]         reg_off,
  input  logic [IMM_W-1:0]      imm_off,
  input  logic [1:0]            shift_kind,
  input  logic [SHAMT_W-1:0]    shift_amt,
  input  logic                  is_byte,
  output logic                  out_valid,
  output logic [DW-1:0]         eff_addr,
  output logic [DW-1:0]         wb_value,
  output logic                  wb_en,
  output logic [ALIGN_BITS-1:0] byte_lane,
  output logic                  misalign
);

  logic [DW-1:0]         offset;
  logic [DW-1:0]         ea_n,   ea_q;
  logic [DW-1:0]         wbv_n,  wbv_q;
  logic                  wb_n,   wb_q;
  logic                  vld_q;
  logic [ALIGN_BITS-1:0] lane_n, lane_q;
  logic                  mis_n,  mis_q;
  logic                  wb_gated;

  lsagu_offset_sel #(.DW(DW), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_offset (
    .use_reg_i (off_src),
    .reg_i     (reg_off),
    .imm_i     (imm_off),
    .kind_i    (shift_kind),
    .amt_i     (shift_amt),
    .offset_o  (offset)
  );

  lsagu_addr_calc #(.DW(DW)) u_calc (
    .mode_i   (addr_mode),
    .base_i   (base_val),
    .offset_i (offset),
    .ea_o     (ea_n),
    .wbv_o    (wbv_n),
    .wb_o     (wb_n)
  );

  lsagu_lane_chk #(.ALIGN_BITS(ALIGN_BITS)) u_lane (
    .ea_lo_i    (ea_n[ALIGN_BITS-1:0]),
    .is_byte_i  (is_byte),
    .lane_o     (lane_n),
    .misalign_o (mis_n)
  );

  // Next-state logic for the control registers.
  always_comb begin
    wb_gated = in_valid & wb_n;
  end

  // Control registers: reset-cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wb_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      wb_q  <= wb_gated;
    end
  end

  // Data registers: loaded only on an accepted request, no reset.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      ea_q   <= ea_n;
      wbv_q  <= wbv_n;
      lane_q <= lane_n;
      mis_q  <= mis_n;
    end
  end

  assign out_valid = vld_q;
  assign wb_en     = wb_q;
  assign eff_addr  = ea_q;
  assign wb_value  = wbv_q;
  assign byte_lane = lane_q;
  assign misalign  = mis_q;

  assert_offset_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mode == 2'b00) |=> (out_valid && !wb_en));

  assert_pre_wb_is_ea_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mode == 2'b01) |=> (wb_en && wb_value == eff_addr));

  assert_post_ea_is_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mode == 2'b10) |=> (wb_en && eff_addr == $past(base_val)));

  assert_rsvd_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mode == 2'b11) |=> (!wb_en && wb_value == eff_addr));

  assert_byte_never_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_byte) |=> (!misalign && byte_lane == eff_addr[ALIGN_BITS-1:0]));

  assert_word_lane_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_byte) |=> (byte_lane == '0 && misalign == (eff_addr[ALIGN_BITS-1:0] != '0)));

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_wb_only_when_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

endmodule

// File: tb/lsagu_top_tb_top.sv
`timescale 1ns/1ps
module lsagu_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  addr_mode;
  logic        off_src;
  logic [31:0] base_val;
  logic [31:0] reg_off;
  logic [11:0] imm_off;
  logic [1:0]  shift_kind;
  logic [5:0]  shift_amt;
  logic        is_byte;
  logic        out_valid;
  logic [31:0] eff_addr;
  logic [31:0] wb_value;
  logic        wb_en;
  logic [1:0]  byte_lane;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lsagu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_mode(addr_mode),
    .off_src(off_src), .base_val(base_val), .reg_off(reg_off), .imm_off(imm_off),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .is_byte(is_byte),
    .out_valid(out_valid), .eff_addr(eff_addr), .wb_value(wb_value), .wb_en(wb_en),
    .byte_lane(byte_lane), .misalign(misalign)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: offset value from the requirements.
  function automatic logic [31:0] ref_offset(bit src, logic [31:0] r, logic [11:0] imm,
                                             logic [1:0] kd, logic [5:0] amt);
    int a;
    a = int'(amt);
    if (!src) return 32'(int'($signed(imm)));
    if (a == 0 || a > 31 || kd == 2'b11) return r;
    case (kd)
      2'b00:   return r << a;
      2'b01:   return r >> a;
      default: return 32'($signed(r) >>> a);
    endcase
  endfunction

  // Drive one request at a falling edge, compare everything at the next falling edge.
  task automatic step(bit v, logic [1:0] md, bit src, logic [31:0] b, logic [31:0] r,
                      int imm, logic [1:0] kd, int amt, bit byt, string tag);
    logic [31:0] off, sum, ea, wbv;
    bit          wbe, mis;
    logic [1:0]  lane;
    in_valid = v; addr_mode = md; off_src = src; base_val = b; reg_off = r;
    imm_off = imm[11:0]; shift_kind = kd; shift_amt = amt[5:0]; is_byte = byt;
    off  = ref_offset(src, r, imm[11:0], kd, amt[5:0]);
    sum  = b + off;
    ea   = (md == 2'b10) ? b : sum;
    wbv  = sum;
    wbe  = v && (md == 2'b01 || md == 2'b10);
    lane = byt ? ea[1:0] : 2'b00;
    mis  = !byt && (ea[1:0] != 2'b00);
    @(negedge clk);
    chk(tag, "out_valid", 32'(out_valid), 32'(v));
    chk(tag, "wb_en", 32'(wb_en), 32'(wbe));
    if (v) begin
      chk(tag, "eff_addr", eff_addr, ea);
      chk(tag, "wb_value", wb_value, wbv);
      chk(tag, "byte_lane", 32'(byte_lane), 32'(lane));
      chk(tag, "misalign", 32'(misalign), 32'(mis));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog act=%0d exp=<%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; addr_mode = 2'b00; off_src = 1'b0;
    base_val = '0; reg_off = '0; imm_off = '0; shift_kind = 2'b00; shift_amt = '0; is_byte = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R11", "wb_en in reset", 32'(wb_en), 32'd0);
    rst_n = 1'b1;

    // R1: register-indirect and offset mode
    step(1, 2'b00, 0, 32'h0000_2000, 32'h0, 0, 2'b00, 0, 0, "R1");
    step(1, 2'b00, 0, 32'h0000_1000, 32'h0, -100, 2'b00, 0, 0, "R5");
    step(1, 2'b00, 0, 32'h0000_1000, 32'h0, 2047, 2'b00, 0, 1, "R5");
    step(1, 2'b00, 0, 32'h0000_1000, 32'h0, -2048, 2'b00, 0, 0, "R5");
    // R5: modulo wrap
    step(1, 2'b01, 0, 32'hFFFF_FFF0, 32'h0, 32'h20, 2'b00, 0, 0, "R5");
    step(1, 2'b00, 0, 32'h0000_0010, 32'h0, -32, 2'b00, 0, 0, "R5");
    // R2: pre-indexed
    step(1, 2'b01, 0, 32'h0000_4000, 32'h0, 32'ha0, 2'b00, 0, 0, "R2");
    step(1, 2'b01, 1, 32'h0000_4000, 32'h0000_0123, 7, 2'b11, 0, 1, "R2");
    // R3: post-indexed
    step(1, 2'b10, 1, 32'h0000_8000, 32'h0000_0010, 0, 2'b00, 2, 1, "R3");
    step(1, 2'b10, 0, 32'h0000_8003, 32'h0, -8, 2'b00, 0, 0, "R3");
    // R4: reserved mode
    step(1, 2'b11, 0, 32'h0000_0100, 32'h0, 64, 2'b00, 0, 0, "R4");
    step(1, 2'b11, 1, 32'h0000_0100, 32'h0000_0040, 0, 2'b01, 3, 0, "R4");
    // R6: shift kinds
    step(1, 2'b01, 1, 32'h0, 32'h8000_0F00, 0, 2'b00, 4, 0, "R6");
    step(1, 2'b01, 1, 32'h0, 32'h8000_0F00, 0, 2'b01, 4, 0, "R6");
    step(1, 2'b01, 1, 32'h0, 32'h8000_0F00, 0, 2'b10, 4, 0, "R6");
    step(1, 2'b01, 1, 32'h0, 32'h8000_0F00, 0, 2'b10, 31, 0, "R6");
    step(1, 2'b01, 1, 32'h0, 32'h7000_0F00, 0, 2'b10, 31, 0, "R6");
    step(1, 2'b01, 1, 32'h0, 32'h0000_0001, 0, 2'b00, 31, 0, "R6");
    step(1, 2'b01, 1, 32'h10, 32'h8000_0F00, 0, 2'b11, 5, 0, "R6");
    // R7: out-of-range amounts
    step(1, 2'b01, 1, 32'h10, 32'h8000_0F04, 0, 2'b10, 0, 0, "R7");
    step(1, 2'b01, 1, 32'h10, 32'h8000_0F04, 0, 2'b00, 32, 0, "R7");
    step(1, 2'b01, 1, 32'h10, 32'h8000_0F04, 0, 2'b01, 63, 0, "R7");
    step(1, 2'b01, 1, 32'h10, 32'h8000_0F04, 0, 2'b10, 33, 0, "R7");
    // R8: unselected source has no effect
    step(1, 2'b00, 1, 32'h200, 32'h0000_0040, -1, 2'b11, 0, 0, "R8");
    step(1, 2'b00, 1, 32'h200, 32'h0000_0040, 1000, 2'b11, 0, 0, "R8");
    step(1, 2'b00, 0, 32'h200, 32'hDEAD_BEEF, 12, 2'b00, 3, 0, "R8");
    step(1, 2'b00, 0, 32'h200, 32'h1234_5678, 12, 2'b10, 9, 0, "R8");
    // R9: lanes and misalignment
    for (int k = 0; k < 4; k++) begin
      step(1, 2'b00, 0, 32'h0000_0300, 32'h0, k, 2'b00, 0, 0, "R9");
      step(1, 2'b00, 0, 32'h0000_0300, 32'h0, k, 2'b00, 0, 1, "R9");
    end
    // R10: idle gaps and back-to-back
    step(0, 2'b01, 0, 32'h55, 32'h0, 4, 2'b00, 0, 0, "R10");
    step(0, 2'b10, 0, 32'h55, 32'h0, 4, 2'b00, 0, 0, "R10");
    step(1, 2'b10, 0, 32'h55, 32'h0, 4, 2'b00, 0, 0, "R10");
    step(1, 2'b01, 0, 32'h99, 32'h0, 8, 2'b00, 0, 0, "R10");
    step(0, 2'b00, 0, 32'h0, 32'h0, 0, 2'b00, 0, 0, "R10");

    // R11: reset mid-run clears without a clock edge
    step(1, 2'b01, 0, 32'h40, 32'h0, 4, 2'b00, 0, 0, "R11");
    #1 rst_n = 1'b0;
    #0.5;
    chk("R11", "out_valid after async reset", 32'(out_valid), 32'd0);
    chk("R11", "wb_en after async reset", 32'(wb_en), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11", "out_valid held in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    // Random mix over all modes and offset forms.
    for (int n = 0; n < 600; n++) begin
      logic [1:0] md;
      logic [1:0] kd;
      md = 2'($urandom_range(0, 3));
      kd = 2'($urandom_range(0, 3));
      step(bit'($urandom_range(0, 3) != 0), md, bit'($urandom_range(0, 1)), $urandom, $urandom,
           int'($urandom_range(0, 4095)), kd, int'($urandom_range(0, 63)),
           bit'($urandom_range(0, 1)),
           (md == 2'b00) ? "R1" : (md == 2'b01) ? "R2" : (md == 2'b10) ? "R3" : "R4");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule